// File: doc/BRIEF.md
# Translation Context Qualifier

This block sits at the front of an address translation pipeline. Each request carries a 64-bit effective address, an access kind, a hypervisor-mode flag, a relocation flag and the current values of the partition-ID and process-ID registers. The block works out which translation context applies to the request. The two most significant address bits select one of four quadrants. Together with the hypervisor flag, the quadrant decides whether the effective partition ID and process ID come from the registers or are forced to zero.

A few requests cannot be qualified. These are addresses with any bit set in the reserved field 61:52, and guest accesses to the two quadrants that are closed to guests. For such a request the block reports a segment fault instead of IDs. The fault report names the vector to take, tells whether a fault address is captured, and carries a strobe that clears the error code.

When relocation is off in hypervisor mode, no context is needed. The block then returns a real-mode address built from the effective address and a real-mode offset register.

Requests enter through a valid/ready handshake. The result appears one cycle after acceptance and stays registered until the consumer takes it. A small two-state machine controls the handshake:
- EMPTY means no result is held.
- FULL means a result is held.

Its transitions are:
- EMPTY to FULL when a request is accepted.
- FULL to EMPTY when the result is taken and no new request arrives.
- FULL to FULL when the result is refused, or when it is taken in the same cycle that a new request is accepted.

Top module: `tcq_context_qualifier`

## Requirements
- R1: When a request is not real mode and any of effective address bits 61:52 is 1, the result kind is segment fault (kind code 2), and the partition and process outputs are 0.
- R2: With hypervisor flag 1 and relocation 1, the quadrant (address bits 63:62) maps as follows: 0 gives partition 0 with the process register; 1 gives the partition register with the process register; 2 gives the partition register with process 0; 3 gives partition 0 with process 0. The result kind is IDs (kind code 0).
- R3: With hypervisor flag 0, quadrant 0 gives the partition register with the process register, and quadrant 3 gives the partition register with process 0. The result kind is IDs.
- R4: With hypervisor flag 0, quadrants 1 and 2 give a segment fault.
- R5: With hypervisor flag 1 and relocation 0, the result kind is real (kind code 1). The address output is the effective address with bits 63:60 cleared. The offset register is ORed in only when address bit 63 is 0, and the ID outputs are 0.
- R6: On a segment fault the error-clear strobe is 1. A fetch (access code 2) selects vector code 1 and gives fault address 0. A load (code 0) or store (code 1) selects vector code 2 and gives fault address equal to the effective address. A result that is not a fault has vector code 0, fault address 0 and strobe 0.
- R7: With hypervisor flag 0 and relocation 0, the request is still qualified into IDs or a fault by R1, R3 and R4, never into a real address.
- R8: A result becomes valid in the cycle after its request is accepted. It stays valid and unchanged while the consumer's ready input is 0.
- R9: After reset the result valid output is 0 and the request ready output is 1.
- R10: While a result is held, the request ready output equals the consumer ready input. When a result is taken and a request is accepted in the same cycle, the new result is valid in the next cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_ea | input | 64 | Effective address |
| req_access | input | 2 | 0 load, 1 store, 2 fetch |
| req_hv | input | 1 | Hypervisor mode |
| req_reloc | input | 1 | Relocation enabled |
| part_reg | input | 32 | Partition-ID register value |
| proc_reg | input | 32 | Process-ID register value |
| real_offset | input | 64 | Real-mode offset register value |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_kind | output | 2 | 0 IDs, 1 real address, 2 segment fault |
| rsp_part | output | 32 | Effective partition ID |
| rsp_proc | output | 32 | Effective process ID |
| rsp_raddr | output | 64 | Real-mode address |
| rsp_vector | output | 2 | 0 none, 1 instruction segment, 2 data segment |
| rsp_fault_addr | output | 64 | Captured fault address |
| rsp_clr_err | output | 1 | Clear error code on fault |

## Verification
Draining a held result and accepting a new request can happen in the same cycle. This is the FULL-to-FULL transition with the consumer's ready at 1. The bench provokes it by keeping requests back to back while the consumer's ready is toggled at random, and also by long stalls with the request held. A behavioural queue-free model in the bench predicts, on every clock, the valid state, req_ready and every result field. A lost, duplicated or early-updated result therefore shows up as a mismatch in the cycle where it happens.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

    typedef enum logic [1:0] {
        RES_IDS  = 2'd0,
        RES_REAL = 2'd1,
        RES_SEGF = 2'd2
    } res_kind_e;

    typedef enum logic [1:0] {
        VEC_NONE = 2'd0,
        VEC_ISEG = 2'd1,
        VEC_DSEG = 2'd2
    } seg_vec_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } access_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hs_state_e;

endpackage

// File: rtl/tcq_range_check.sv
module tcq_range_check #(
    parameter int FIELD_W = 10
) (
    input  logic [FIELD_W-1:0] field,
    output logic               bad
);
    // any reserved bit set disqualifies the address
    always_comb begin
        bad = |field;
    end
endmodule

// File: rtl/tcq_quadrant_map.sv
module tcq_quadrant_map #(
    parameter int PART_W = 32,
    parameter int PROC_W = 32
) (
    input  logic [1:0]        quad,
    input  logic              hv,
    input  logic [PART_W-1:0] part_reg,
    input  logic [PROC_W-1:0] proc_reg,
    output logic [PART_W-1:0] part_id,
    output logic [PROC_W-1:0] proc_id,
    output logic              illegal
);
    always_comb begin
        part_id = '0;
        proc_id = '0;
        illegal = 1'b0;
        if (hv) begin
            unique case (quad)
                2'd0: proc_id = proc_reg;
                2'd1: begin
                    part_id = part_reg;
                    proc_id = proc_reg;
                end
                2'd2: part_id = part_reg;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin
                    part_id = part_reg;
                    proc_id = proc_reg;
                end
                2'd3: part_id = part_reg;
                default: illegal = 1'b1;
            endcase
        end
    end

    // R4: a guest never gets IDs from the two closed quadrants
    always_comb begin
        if (!hv && (quad == 2'd1 || quad == 2'd2))
            a_guest_closed_r4: assert (illegal && part_id == '0 && proc_id == '0);
    end
endmodule

// File: rtl/tcq_real_addr.sv
module tcq_real_addr #(
    parameter int EA_W     = 64,
    parameter int CLR_BITS = 4
) (
    input  logic [EA_W-1:0] ea,
    input  logic [EA_W-1:0] offset,
    output logic [EA_W-1:0] raddr
);
    logic [EA_W-1:0] stripped;

    generate
        if (CLR_BITS == 0) begin : g_noclr
            assign stripped = ea;
        end else begin : g_clr
            assign stripped = {{CLR_BITS{1'b0}}, ea[EA_W-CLR_BITS-1:0]};
        end
    endgenerate

    // offset applies only in the lower half of the address space
    always_comb begin
        raddr = ea[EA_W-1] ? stripped : (stripped | offset);
    end
endmodule

// File: rtl/tcq_fault_sel.sv
module tcq_fault_sel
    import tcq_pkg::*;
#(
    parameter int EA_W = 64
) (
    input  logic            fault,
    input  logic [1:0]      access,
    input  logic [EA_W-1:0] ea,
    output seg_vec_e        vector,
    output logic [EA_W-1:0] fault_addr,
    output logic            clr_err
);
    always_comb begin
        vector     = VEC_NONE;
        fault_addr = '0;
        clr_err    = 1'b0;
        if (fault) begin
            clr_err = 1'b1;
            if (access == ACC_FETCH) begin
                vector = VEC_ISEG;
            end else begin
                vector     = VEC_DSEG;
                fault_addr = ea;
            end
        end
    end
endmodule

// File: rtl/tcq_context_qualifier.sv
module tcq_context_qualifier
    import tcq_pkg::*;
#(
    parameter int EA_W     = 64,
    parameter int PART_W   = 32,
    parameter int PROC_W   = 32,
    parameter int CHK_HI   = 61,
    parameter int CHK_LO   = 52,
    parameter int CLR_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [1:0]        req_access,
    input  logic              req_hv,
    input  logic              req_reloc,
    input  logic [PART_W-1:0] part_reg,
    input  logic [PROC_W-1:0] proc_reg,
    input  logic [EA_W-1:0]   real_offset,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_kind,
    output logic [PART_W-1:0] rsp_part,
    output logic [PROC_W-1:0] rsp_proc,
    output logic [EA_W-1:0]   rsp_raddr,
    output logic [1:0]        rsp_vector,
    output logic [EA_W-1:0]   rsp_fault_addr,
    output logic              rsp_clr_err
);
    localparam int CHK_W  = CHK_HI - CHK_LO + 1;
    localparam int QUAD_H = EA_W - 1;
    localparam int QUAD_L = EA_W - 2;

    hs_state_e state_q, state_d;
    logic      accept;

    logic              range_bad;
    logic              quad_illegal;
    logic [PART_W-1:0] map_part;
    logic [PROC_W-1:0] map_proc;
    logic [EA_W-1:0]   real_addr;
    logic              real_mode;
    logic              seg_fault;
    seg_vec_e          vec_d;
    logic [EA_W-1:0]   faddr_d;
    logic              clr_d;

    res_kind_e         kind_d;
    logic [PART_W-1:0] part_d;
    logic [PROC_W-1:0] proc_d;
    logic [EA_W-1:0]   raddr_d;

    tcq_range_check #(.FIELD_W(CHK_W)) u_range (
        .field (req_ea[CHK_HI:CHK_LO]),
        .bad   (range_bad)
    );

    tcq_quadrant_map #(.PART_W(PART_W), .PROC_W(PROC_W)) u_quad (
        .quad     (req_ea[QUAD_H:QUAD_L]),
        .hv       (req_hv),
        .part_reg (part_reg),
        .proc_reg (proc_reg),
        .part_id  (map_part),
        .proc_id  (map_proc),
        .illegal  (quad_illegal)
    );

    tcq_real_addr #(.EA_W(EA_W), .CLR_BITS(CLR_BITS)) u_real (
        .ea     (req_ea),
        .offset (real_offset),
        .raddr  (real_addr)
    );

    tcq_fault_sel #(.EA_W(EA_W)) u_fault (
        .fault      (seg_fault),
        .access     (req_access),
        .ea         (req_ea),
        .vector     (vec_d),
        .fault_addr (faddr_d),
        .clr_err    (clr_d)
    );

    // result selection: real mode bypasses qualification entirely
    always_comb begin
        real_mode = req_hv && !req_reloc;
        seg_fault = !real_mode && (range_bad || quad_illegal);
        kind_d    = RES_IDS;
        part_d    = '0;
        proc_d    = '0;
        raddr_d   = '0;
        if (real_mode) begin
            kind_d  = RES_REAL;
            raddr_d = real_addr;
        end else if (seg_fault) begin
            kind_d = RES_SEGF;
        end else begin
            part_d = map_part;
            proc_d = map_proc;
        end
    end

    // handshake state machine
    always_comb begin
        req_ready = (state_q == ST_EMPTY) || rsp_ready;
        accept    = req_valid && req_ready;
        state_d   = state_q;
        unique case (state_q)
            ST_EMPTY: if (req_valid) state_d = ST_FULL;
            ST_FULL:  if (rsp_ready && !req_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // output registers, loaded on acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_kind       <= RES_IDS;
            rsp_part       <= '0;
            rsp_proc       <= '0;
            rsp_raddr      <= '0;
            rsp_vector     <= VEC_NONE;
            rsp_fault_addr <= '0;
            rsp_clr_err    <= 1'b0;
        end else if (accept) begin
            rsp_kind       <= kind_d;
            rsp_part       <= part_d;
            rsp_proc       <= proc_d;
            rsp_raddr      <= raddr_d;
            rsp_vector     <= vec_d;
            rsp_fault_addr <= faddr_d;
            rsp_clr_err    <= clr_d;
        end
    end

    assign rsp_valid = (state_q == ST_FULL);

    // R1: reserved-field violation outside real mode yields a fault
    p_reserved_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(req_hv && !req_reloc) && (|req_ea[CHK_HI:CHK_LO]))
        |=> (rsp_kind == RES_SEGF && rsp_part == '0 && rsp_proc == '0));

    // R4: guest access to quadrant 1 or 2 faults
    p_guest_quad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_hv && (req_ea[QUAD_H:QUAD_L] == 2'd1 || req_ea[QUAD_H:QUAD_L] == 2'd2))
        |=> rsp_kind == RES_SEGF);

    // R5: hypervisor with relocation off gives a real address
    p_real_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_hv && !req_reloc) |=> rsp_kind == RES_REAL);

    // R6: a vector is reported exactly for fault results
    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_kind == RES_SEGF) == (rsp_vector != VEC_NONE)
                       && (rsp_kind == RES_SEGF) == rsp_clr_err));

    // R7: guest with relocation off is never a real-address result
    p_guest_no_real_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_hv) |=> rsp_kind != RES_REAL);

    // R8: acceptance produces a result on the next cycle
    p_accept_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    // R8: a refused result holds still
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_part)
            && $stable(rsp_proc) && $stable(rsp_raddr) && $stable(rsp_fault_addr)));

    // R10: while holding, ready follows the consumer
    p_ready_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready == rsp_ready));

    // R9: with nothing held the block can always accept
    p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);
endmodule

// File: tb/tcq_context_qualifier_test.sv
module tcq_context_qualifier_test;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] part;
        logic [31:0] proc;
        logic [63:0] raddr;
        logic [1:0]  vec;
        logic [63:0] faddr;
        logic        clr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_ea;
    logic [1:0]  req_access;
    logic        req_hv;
    logic        req_reloc;
    logic [31:0] part_reg;
    logic [31:0] proc_reg;
    logic [63:0] real_offset;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_part;
    logic [31:0] rsp_proc;
    logic [63:0] rsp_raddr;
    logic [1:0]  rsp_vector;
    logic [63:0] rsp_fault_addr;
    logic        rsp_clr_err;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tcq_context_qualifier uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ea(req_ea), .req_access(req_access), .req_hv(req_hv), .req_reloc(req_reloc),
        .part_reg(part_reg), .proc_reg(proc_reg), .real_offset(real_offset),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
        .rsp_part(rsp_part), .rsp_proc(rsp_proc), .rsp_raddr(rsp_raddr),
        .rsp_vector(rsp_vector), .rsp_fault_addr(rsp_fault_addr), .rsp_clr_err(rsp_clr_err)
    );

    // behavioural expectation of one request
    function automatic exp_t predict(input logic [63:0] ea, input logic [1:0] acc,
                                     input logic hv, input logic reloc,
                                     input logic [31:0] pr, input logic [31:0] pd,
                                     input logic [63:0] off, output string tag);
        exp_t e;
        int   q;
        bit   fault;
        e     = '0;
        q     = int'(ea[63:62]);
        fault = 0;
        if (hv && !reloc) begin
            tag     = "R5";
            e.kind  = 2'd1;
            e.raddr = ea & 64'h0FFF_FFFF_FFFF_FFFF;
            if (ea[63] == 1'b0) e.raddr = e.raddr | off;
        end else if (ea[61:52] != 10'd0) begin
            tag   = "R1";
            fault = 1;
        end else if (hv) begin
            tag = "R2";
            if (q == 1 || q == 2) e.part = pr;
            if (q == 0 || q == 1) e.proc = pd;
        end else if (q == 0 || q == 3) begin
            tag    = reloc ? "R3" : "R7";
            e.part = pr;
            if (q == 0) e.proc = pd;
        end else begin
            tag   = reloc ? "R4" : "R7";
            fault = 1;
        end
        if (fault) begin
            e.kind = 2'd2;
            e.clr  = 1'b1;
            if (acc == 2'd2) e.vec = 2'd1;
            else begin
                e.vec   = 2'd2;
                e.faddr = ea;
            end
        end
        return e;
    endfunction

    // cycle model: valid state and held result
    bit    m_valid = 0;
    exp_t  m_res;
    string m_tag = "R9";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0;
        end else if (req_valid && (!m_valid || rsp_ready)) begin
            string t;
            m_res   = predict(req_ea, req_access, req_hv, req_reloc,
                              part_reg, proc_reg, real_offset, t);
            m_tag   = t;
            m_valid = 1;
        end else if (rsp_ready) begin
            m_valid = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        exp_t a;
        check(rsp_valid == m_valid, "R8", "rsp_valid", 64'(rsp_valid), 64'(m_valid));
        check(req_ready == (!m_valid || rsp_ready), m_valid ? "R10" : "R9", "req_ready",
              64'(req_ready), 64'(!m_valid || rsp_ready));
        if (m_valid && rsp_valid) begin
            a = {rsp_kind, rsp_part, rsp_proc, rsp_raddr, rsp_vector, rsp_fault_addr, rsp_clr_err};
            check(a.kind == m_res.kind, m_tag, "kind", 64'(a.kind), 64'(m_res.kind));
            check(a.part == m_res.part && a.proc == m_res.proc, m_tag, "part/proc",
                  {a.part, a.proc}, {m_res.part, m_res.proc});
            check(a.raddr == m_res.raddr, m_tag, "raddr", a.raddr, m_res.raddr);
            check(a.vec == m_res.vec && a.clr == m_res.clr, "R6", "vector/clr",
                  64'({a.vec, a.clr}), 64'({m_res.vec, m_res.clr}));
            check(a.faddr == m_res.faddr, "R6", "fault_addr", a.faddr, m_res.faddr);
        end
    endtask

    task automatic step(input bit v, input logic [63:0] ea, input logic [1:0] acc,
                        input bit hv, input bit reloc, input bit rdy);
        @(negedge clk);
        req_valid  = v;
        req_ea     = ea;
        req_access = acc;
        req_hv     = hv;
        req_reloc  = reloc;
        rsp_ready  = rdy;
        #1;
        compare_all();
    endtask

    function automatic logic [63:0] rand_ea();
        logic [63:0] e;
        e = {$urandom, $urandom};
        if ($urandom_range(3) != 0) e[61:52] = '0;
        return e;
    endfunction

    initial begin
        rst_n       = 1'b0;
        req_valid   = 1'b0;
        req_ea      = '0;
        req_access  = 2'd0;
        req_hv      = 1'b0;
        req_reloc   = 1'b1;
        part_reg    = 32'h0000_0A5C;
        proc_reg    = 32'h0000_1234;
        real_offset = 64'h0000_0040_0000_0000;
        rsp_ready   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(rsp_valid == 1'b0, "R9", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        check(req_ready == 1'b1, "R9", "reset req_ready", 64'(req_ready), 64'd1);
        rst_n = 1'b1;

        // R2: hypervisor quadrants
        for (int q = 0; q < 4; q++) step(1, {2'(q), 62'h0000_0000_0ABC_D000}, 2'd0, 1, 1, 1);
        // R3 / R4: guest quadrants, each access kind
        for (int q = 0; q < 4; q++)
            for (int a = 0; a < 3; a++) step(1, {2'(q), 62'h0000_0000_0001_2000}, 2'(a), 0, 1, 1);
        // R1: reserved field, fetch and store
        step(1, 64'h0010_0000_0000_1000, 2'd2, 1, 1, 1);
        step(1, 64'hC200_0000_0000_1000, 2'd1, 0, 1, 1);
        // R5: real mode, top bit clear then set
        step(1, 64'h3123_4567_89AB_CDEF, 2'd0, 1, 0, 1);
        step(1, 64'hF123_4567_89AB_CDEF, 2'd2, 1, 0, 1);
        step(1, 64'h0FF0_0000_0000_0000, 2'd0, 1, 0, 1);
        // R7: guest, relocation off
        step(1, 64'h0000_0000_0000_4000, 2'd0, 0, 0, 1);
        step(1, 64'h4000_0000_0000_4000, 2'd1, 0, 0, 1);
        // R8: stall with a new request waiting
        for (int i = 0; i < 5; i++) step(1, 64'h8000_0000_0000_0008, 2'd0, 1, 1, 0);
        step(1, 64'hC000_0000_0000_0010, 2'd2, 0, 1, 1);
        step(0, '0, 2'd0, 0, 1, 1);
        step(0, '0, 2'd0, 0, 1, 1);
        // R10: random mix, back-to-back accept with drain
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) begin
                part_reg    = $urandom;
                proc_reg    = $urandom;
                real_offset = {$urandom, $urandom};
            end
            step($urandom_range(3) != 0, rand_ea(), 2'($urandom_range(2)),
                 1'($urandom), 1'($urandom_range(3) != 0), $urandom_range(2) != 0);
        end
        step(0, '0, 2'd0, 0, 1, 1);
        step(0, '0, 2'd0, 0, 1, 1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule